// File: doc/BRIEF.md
# Two-State Rotary Switching Element

This block is one reversible routing cell. It has four pulse inputs, one for each side (north, east, south, west), and four pulse outputs for the same sides. One bit of state records which way an internal bar lies: horizontal or vertical. In each clock cycle at most one input side may carry a pulse. An accepted pulse leaves on exactly one output side. Depending on how the pulse meets the bar, the bar may also turn.

A pulse that travels along the bar passes straight through to the far side, and the bar stays as it is. A pulse that meets the bar across its length turns right, and the bar turns a quarter turn, so the state toggles. The result is a one-to-one map from (state, input side) to (state, output side), so any move can be traced back.

The output is registered and appears one clock after the input. The bar update happens on the same edge. A cycle with more than one input pulse is rejected: a flag rises for one cycle, no output appears and the bar does not move. A synchronous active-low reset loads the starting orientation from a parameter and clears every output.

Top module: `rotary_switch`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next outputs are `pulse_out` = 0 and `multi_err` = 0, and `bar_vert` equals the `INIT_VERT` parameter (0 = horizontal, 1 = vertical). This holds even if an input pulse is present in that cycle.
- R2: A cycle with `pulse_in` = 0 yields `pulse_out` = 0 and `multi_err` = 0 after the next edge, and `bar_vert` is unchanged.
- R3: With the bar horizontal (`bar_vert` = 0), an east pulse (`pulse_in` bit 1) leaves on west (`pulse_out` bit 3), and a west pulse (bit 3) leaves on east (bit 1). The bar stays horizontal.
- R4: With the bar horizontal, a north pulse (bit 0) leaves on west (bit 3), and a south pulse (bit 2) leaves on east (bit 1). The bar becomes vertical.
- R5: With the bar vertical, a north pulse (bit 0) leaves on south (bit 2), and a south pulse (bit 2) leaves on north (bit 0). The bar stays vertical.
- R6: With the bar vertical, an east pulse (bit 1) leaves on north (bit 0), and a west pulse (bit 3) leaves on south (bit 2). The bar becomes horizontal.
- R7: Each single input pulse yields exactly one output pulse, on the edge that samples it. `pulse_out` never has more than one bit set.
- R8: A cycle with two or more `pulse_in` bits set raises `multi_err` for exactly the following cycle, with `pulse_out` = 0 and `bar_vert` unchanged.
- R9: Across both states and all four input sides, the eight resulting (`bar_vert`, `pulse_out`) pairs are all different, so every move can be undone.
- R10: Pulses on consecutive cycles are each routed using the bar orientation left by the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| pulse_in | input | 4 | Input pulses; bit 0 north, 1 east, 2 south, 3 west |
| pulse_out | output | 4 | Registered output pulses, same bit order |
| bar_vert | output | 1 | Bar orientation: 0 horizontal, 1 vertical |
| multi_err | output | 1 | One-cycle flag for a rejected multi-pulse cycle |

## Verification
A turn of the bar and the exit of the pulse that caused it happen in the same cycle. The bench provokes this by sending a pulse on every clock, with no idle cycle between pulses, and judges each output against a model that works out the exit side from geometry: straight through, or turning right. A reset that arrives together with an input pulse is also provoked, and the bench judges that reset wins. Every cycle is compared, including rejected multi-pulse cycles that are mixed into the back-to-back stream.

// File: rtl/rot_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the rotary switching element.
// Side order is fixed: north, east, south, west, going clockwise.
package rot_pkg;
    localparam int unsigned SIDES = 4;
    localparam int unsigned IDX_N = 0;
    localparam int unsigned IDX_E = 1;
    localparam int unsigned IDX_S = 2;
    localparam int unsigned IDX_W = 3;

    typedef logic [SIDES-1:0] side_vec_t;

    localparam side_vec_t HOT_N = side_vec_t'(1) << IDX_N;
    localparam side_vec_t HOT_E = side_vec_t'(1) << IDX_E;
    localparam side_vec_t HOT_S = side_vec_t'(1) << IDX_S;
    localparam side_vec_t HOT_W = side_vec_t'(1) << IDX_W;

    typedef enum logic {
        BAR_H = 1'b0,
        BAR_V = 1'b1
    } bar_e;
endpackage

// File: rtl/rot_pulse_screen.sv
`timescale 1ns/1ps
// Classifies an input pulse vector as carrying exactly one pulse or more than one.
// Assumes nothing about the input; an all-zero vector sets neither output.
module rot_pulse_screen #(
    parameter int unsigned WIDTH = rot_pkg::SIDES
) (
    input  logic [WIDTH-1:0] pulses,
    output logic             single,
    output logic             multi
);
    localparam int unsigned CNT_W = $clog2(WIDTH + 1);

    logic [CNT_W-1:0] cnt;

    // Population count of the incoming pulses.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < WIDTH; i++) begin
            cnt = cnt + CNT_W'(pulses[i]);
        end
    end

    // Decode the count into the two classes.
    always_comb begin
        single = (cnt == CNT_W'(1));
        multi  = (cnt > CNT_W'(1));
    end
endmodule

// File: rtl/rot_route.sv
`timescale 1ns/1ps
// Combinational move function: exit side and whether the bar turns.
// Assumes hit is one-hot; any other value gives no exit and no turn.
module rot_route
    import rot_pkg::*;
(
    input  bar_e      bar,
    input  side_vec_t hit,
    output side_vec_t exit_vec,
    output logic      rotate
);
    // Select the exit side and the turn for the present bar orientation.
    always_comb begin
        exit_vec = '0;
        rotate   = 1'b0;
        if (bar == BAR_H) begin
            case (hit)
                HOT_N:   begin exit_vec = HOT_W; rotate = 1'b1; end
                HOT_E:   begin exit_vec = HOT_W; end
                HOT_S:   begin exit_vec = HOT_E; rotate = 1'b1; end
                HOT_W:   begin exit_vec = HOT_E; end
                default: ;
            endcase
        end else begin
            case (hit)
                HOT_N:   begin exit_vec = HOT_S; end
                HOT_E:   begin exit_vec = HOT_N; rotate = 1'b1; end
                HOT_S:   begin exit_vec = HOT_N; end
                HOT_W:   begin exit_vec = HOT_S; rotate = 1'b1; end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rotary_switch.sv
`timescale 1ns/1ps
// Two-state rotary switching element with a registered output.
// Assumes at most one input pulse per cycle; a cycle with more is flagged and dropped.
// Reset is synchronous and active low; INIT_VERT selects the bar orientation after reset.
module rotary_switch
    import rot_pkg::*;
#(
    parameter bit INIT_VERT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SIDES-1:0] pulse_in,
    output logic [SIDES-1:0] pulse_out,
    output logic             bar_vert,
    output logic             multi_err
);
    localparam bar_e BAR_INIT = INIT_VERT ? BAR_V : BAR_H;

    bar_e      bar_q;
    side_vec_t out_q;
    logic      err_q;
    logic      single;
    logic      multi;
    side_vec_t exit_vec;
    logic      rotate;

    rot_pulse_screen #(.WIDTH(SIDES)) u_screen (
        .pulses (pulse_in),
        .single (single),
        .multi  (multi)
    );

    rot_route u_route (
        .bar      (bar_q),
        .hit      (pulse_in),
        .exit_vec (exit_vec),
        .rotate   (rotate)
    );

    // Register the exit pulse, the error flag and the bar orientation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bar_q <= BAR_INIT;
            out_q <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= multi;
            out_q <= single ? exit_vec : '0;
            if (single && rotate) begin
                bar_q <= (bar_q == BAR_H) ? BAR_V : BAR_H;
            end
        end
    end

    assign pulse_out = out_q;
    assign bar_vert  = (bar_q == BAR_V);
    assign multi_err = err_q;

    AST_OUT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulse_out)); // R7
    AST_ONE_IN_ONE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(pulse_in) |=> ($countones(pulse_out) == 1)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_in == '0) |=> (pulse_out == '0 && !multi_err && $stable(bar_vert))); // R2
    AST_MULTI_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pulse_in) > 1) |=> (multi_err && pulse_out == '0 && $stable(bar_vert))); // R8
    AST_H_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bar_vert && (pulse_in == HOT_E || pulse_in == HOT_W)) |=> !bar_vert); // R3
    AST_H_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (!bar_vert && (pulse_in == HOT_N || pulse_in == HOT_S)) |=> bar_vert); // R4
    AST_V_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_vert && (pulse_in == HOT_N || pulse_in == HOT_S)) |=> bar_vert); // R5
    AST_V_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_vert && (pulse_in == HOT_E || pulse_in == HOT_W)) |=> !bar_vert); // R6
endmodule

// File: tb/sim_rotary_switch.sv
`timescale 1ns/1ps
// Self-checking bench: a geometric reference model is compared on every clock.
module sim_rotary_switch;
    localparam int WATCH_CYC = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pulse_in = 4'b0000;
    logic [3:0] pulse_out;
    logic       bar_vert;
    logic       multi_err;

    int  n_checks = 0;
    int  n_fail = 0;
    int  m_bar = 0;
    bit  done = 1'b0;
    logic [4:0] seen [8];

    rotary_switch #(.INIT_VERT(1'b0)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse_in  (pulse_in),
        .pulse_out (pulse_out),
        .bar_vert  (bar_vert),
        .multi_err (multi_err)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [5:0] got, input logic [5:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got bar/err/out=%b expected %b", tag, got, exp);
        end
    endtask

    // Drive one cycle of input and compare the registered result with the model.
    task automatic step(input logic [3:0] v, input string tag);
        int ones;
        int d;
        bit par;
        logic [3:0] exp_out;
        logic exp_err;
        ones = 0;
        d = 0;
        for (int i = 0; i < 4; i++) begin
            if (v[i]) begin
                ones++;
                d = i;
            end
        end
        exp_out = 4'b0000;
        exp_err = 1'b0;
        if (ones > 1) begin
            exp_err = 1'b1;
        end else if (ones == 1) begin
            par = (m_bar == 0) ? (d % 2 == 1) : (d % 2 == 0);
            if (par) begin
                exp_out = 4'(1 << ((d + 2) % 4));
            end else begin
                exp_out = 4'(1 << ((d + 3) % 4));
                m_bar = 1 - m_bar;
            end
        end
        @(negedge clk);
        pulse_in = v;
        @(posedge clk);
        #1;
        check(tag, {bar_vert, multi_err, pulse_out}, {m_bar[0], exp_err, exp_out});
    endtask

    task automatic do_reset(input logic [3:0] v);
        @(negedge clk);
        rst_n = 1'b0;
        pulse_in = v;
        @(posedge clk);
        #1;
        m_bar = 0;
        check("R1", {bar_vert, multi_err, pulse_out}, 6'b000000);
        @(negedge clk);
        rst_n = 1'b1;
        pulse_in = 4'b0000;
    endtask

    initial begin
        logic [7:0] lfsr;
        int clash;
        do_reset(4'b0000);
        // R2 idle cycles
        step(4'b0000, "R2");
        step(4'b0000, "R2");
        // R3 horizontal pass-through
        step(4'b0010, "R3");
        step(4'b1000, "R3");
        // R4 / R5 / R6 corner moves
        step(4'b0001, "R4");
        step(4'b0001, "R5");
        step(4'b0100, "R5");
        step(4'b0010, "R6");
        step(4'b0100, "R4");
        step(4'b1000, "R6");
        // R8 rejected cycles in both states, flag lasts one cycle
        step(4'b0011, "R8");
        step(4'b0000, "R8");
        step(4'b0001, "R4");
        step(4'b1111, "R8");
        step(4'b0101, "R8");
        step(4'b0000, "R8");
        // R10 back-to-back stream with occasional multi pulses (R7 per cycle)
        lfsr = 8'hA5;
        for (int k = 0; k < 60; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (lfsr[7:5] == 3'b111) step(4'b1010, "R10");
            else step(4'(1 << lfsr[1:0]), "R10");
        end
        // R1 reset while vertical, with a pulse present
        step(4'b0001, "R4");
        if (m_bar == 0) step(4'b0001, "R4");
        do_reset(4'b0001);
        step(4'b0000, "R1");
        // R9 enumerate all state/input pairs
        for (int s = 0; s < 2; s++) begin
            for (int d = 0; d < 4; d++) begin
                do_reset(4'b0000);
                if (s == 1) step(4'b0001, "R9");
                step(4'(1 << d), "R9");
                seen[s * 4 + d] = {bar_vert, pulse_out};
            end
        end
        clash = 0;
        for (int a = 0; a < 8; a++) begin
            for (int b = a + 1; b < 8; b++) begin
                if (seen[a] == seen[b]) clash++;
            end
        end
        check("R9", 6'(clash), 6'd0);
        pulse_in = 4'b0000;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(WATCH_CYC * 4);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule